// File: doc/BRIEF.md
# Stepper Idle Current Reduction Controller

This block sits between a microstep sequencer and a coil driver. It holds the two 8-bit drive words that feed the driver and watches for activity on the step, direction and enable lines. A step strobe, a direction change or any other input change counts as activity. When no activity arrives for a set interval, it lowers every coil current field in both held words by one level. It then lights a low-power indicator. The next step strobe reloads fresh words from the sequencer, which restores full current.

When the drive is disabled (enable input high), the held words are forced to zero and the inactivity timer is held clear. The indicator then blinks, using a free-running tick counter. Enabling the drive loads the words presented at its inputs and starts the timer.

Each drive word packs, from the top: the coil A current field in bits [7:6], the coil B current field in bits [5:4], and the coil phase pattern in bits [3:0]. A current field uses 3 for full current, 2 for about half, 1 for about a quarter and 0 for off.

Top module: `stp_idle_reducer`

## Requirements
- R1: While reset is high and in the first cycle after it, both word outputs are zero and the indicator is on. The controller starts in the disabled state.
- R2: Whenever the enable input is high at a clock edge, both word outputs are zero after that edge. This holds even if a step strobe is present.
- R3: In the first edge where enable is low after being disabled, both input words are loaded to the outputs and the indicator turns off.
- R4: While enabled, a step strobe loads both input words to the outputs at the next edge and turns the indicator off. This applies both at full current and at reduced current.
- R5: While enabled, a change strobe without a step turns the indicator off and leaves the output words unchanged. Input words that are presented without a step are ignored.
- R6: The reduction happens exactly PRESC_DIV × 2^TMR_W × OVF_LIMIT edges after the last enabling, step or change edge, and not one edge earlier. Any new activity restarts that count.
- R7: At timeout, each current field (bits [7:6] and [5:4]) of both words drops one level: 3→2, 2→1, 1→0, 0→0. The phase bits [3:0] are kept. The indicator turns on.
- R8: After a reduction and with no further activity, the words and the indicator stay unchanged. The reduction is applied once only.
- R9: The indicator stays on from a reduction until the next step, change or disable.
- R10: While disabled, the indicator follows a tick counter that advances once every TICK_DIV cycles. The indicator is off when either of the counter's top two bits (bits 5 and 6 at BLINK_W = 7) is set, and on otherwise. It lags the counter by one edge.
- R11: A change strobe without a step after a reduction re-arms the timer. A second timeout then lowers the already-reduced fields one more level.
- R12: Disabling the drive from the active or the reduced state clears both word outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Drive enable, low = energised |
| any_change | input | 1 | One-cycle strobe: step, direction or enable changed (synchronised) |
| step_rise | input | 1 | One-cycle strobe on a rising step edge (synchronised) |
| word_a_in | input | FIELD_W*FIELD_N+PHASE_W (8) | First drive word from the sequencer (long PWM slot) |
| word_b_in | input | FIELD_W*FIELD_N+PHASE_W (8) | Second drive word from the sequencer (short PWM slot) |
| word_a_out | output | FIELD_W*FIELD_N+PHASE_W (8) | Held first drive word to the coil driver |
| word_b_out | output | FIELD_W*FIELD_N+PHASE_W (8) | Held second drive word to the coil driver |
| lowpwr_led | output | 1 | Low-power indicator (blinks while disabled) |

## Verification
The bench builds the block with PRESC_DIV = 2, TMR_W = 3, OVF_LIMIT = 2 and TICK_DIV = 2. With these values a timeout arrives 32 edges after the last activity. The full indicator blink period is 256 cycles. This brings within reach the exact edge of the first reduction and a second reduction after a re-arming change. It also makes reachable a timer restart in mid-count and several blink phases, in a few hundred cycles each. The field width, field count and blink width keep their defaults, so every field value 0 to 3 and the real bit positions 5 and 6 of the blink counter are exercised.

// File: rtl/stp_idle_pkg.sv
package stp_idle_pkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_RUN = 2'd1,
    ST_LOW = 2'd2
  } ctl_state_t;

endpackage

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned PRESC_DIV = 32,
  parameter int unsigned TMR_W     = 16,
  parameter int unsigned OVF_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic expire
);

  localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int unsigned OW = $clog2(OVF_LIMIT + 1);
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_DIV - 1);
  localparam logic [OW-1:0] OVF_LAST   = OW'(OVF_LIMIT - 1);

  logic [PW-1:0]    presc_q;
  logic [TMR_W-1:0] tmr_q;
  logic [OW-1:0]    ovf_q;
  logic             presc_hit;
  logic             tmr_wrap;

  assign presc_hit = (presc_q == PRESC_LAST);
  assign tmr_wrap  = presc_hit && (&tmr_q);
  assign expire    = run && !restart && tmr_wrap && (ovf_q == OVF_LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      presc_q <= '0;
      tmr_q   <= '0;
      ovf_q   <= '0;
    end else if (run) begin
      presc_q <= presc_hit ? '0 : presc_q + 1'b1;
      if (presc_hit) tmr_q <= tmr_q + 1'b1;
      if (tmr_wrap)  ovf_q <= (ovf_q == OVF_LAST) ? '0 : ovf_q + 1'b1;
    end
  end

  // R6: overflow count never passes its limit
  p_ovf_range_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_q < OW'(OVF_LIMIT));

  // R6: a timeout only comes from a running timer
  p_expire_running_r6: assert property (@(posedge clk) disable iff (rst)
    expire |-> run);

  // R6: a stopped timer holds its count
  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> ($stable(tmr_q) && $stable(ovf_q)));

endmodule

// File: rtl/blink_gen.sv
module blink_gen #(
  parameter int unsigned TICK_DIV = 8192,
  parameter int unsigned CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] tick_cnt
);

  localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0]    div_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_cnt = cnt_q;

  // R10: tick count advances by one at each divider wrap
  p_tick_advance_r10: assert property (@(posedge clk) disable iff (rst)
    (div_q == DIV_LAST) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R10: tick count holds between wraps
  p_tick_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (div_q != DIV_LAST) |=> $stable(cnt_q));

endmodule

// File: rtl/level_reducer.sv
module level_reducer #(
  parameter int unsigned FIELD_W = 2,
  parameter int unsigned FIELD_N = 2,
  parameter int unsigned PHASE_W = 4
) (
  input  logic [FIELD_W*FIELD_N+PHASE_W-1:0] word_in,
  output logic [FIELD_W*FIELD_N+PHASE_W-1:0] word_out
);

  localparam int unsigned WORD_W = FIELD_W * FIELD_N + PHASE_W;

  logic [FIELD_N-1:0] nz;
  logic [WORD_W-1:0]  mask;

  for (genvar f = 0; f < FIELD_N; f++) begin : g_field
    localparam int unsigned LSB = PHASE_W + f * FIELD_W;
    assign nz[f] = |word_in[LSB +: FIELD_W];
  end

  always_comb begin
    mask = '0;
    for (int f = 0; f < FIELD_N; f++) begin
      mask[PHASE_W + f * FIELD_W] = nz[f];
    end
  end

  // a nonzero field is at least one, so no borrow crosses a field boundary
  assign word_out = word_in - mask;

  // R7: phase pattern passes through, no field grows
  always_comb begin
    p_phase_kept_r7: assert (word_out[PHASE_W-1:0] == word_in[PHASE_W-1:0]);
  end

endmodule

// File: rtl/stp_idle_reducer.sv
module stp_idle_reducer
  import stp_idle_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 32,
  parameter int unsigned TMR_W     = 16,
  parameter int unsigned OVF_LIMIT = 8,
  parameter int unsigned TICK_DIV  = 8192,
  parameter int unsigned BLINK_W   = 7,
  parameter int unsigned FIELD_W   = 2,
  parameter int unsigned FIELD_N   = 2,
  parameter int unsigned PHASE_W   = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               en_n,
  input  logic                               any_change,
  input  logic                               step_rise,
  input  logic [FIELD_W*FIELD_N+PHASE_W-1:0] word_a_in,
  input  logic [FIELD_W*FIELD_N+PHASE_W-1:0] word_b_in,
  output logic [FIELD_W*FIELD_N+PHASE_W-1:0] word_a_out,
  output logic [FIELD_W*FIELD_N+PHASE_W-1:0] word_b_out,
  output logic                               lowpwr_led
);

  localparam int unsigned WORD_W = FIELD_W * FIELD_N + PHASE_W;

  ctl_state_t         st_q;
  logic [WORD_W-1:0]  wa_q, wb_q;
  logic [WORD_W-1:0]  red_a, red_b;
  logic               led_q;
  logic [BLINK_W-1:0] tick_cnt;
  logic               blink_on;
  logic               expire;
  logic               tmr_restart;
  logic               tmr_run;

  assign tmr_restart = en_n || (st_q == ST_OFF) || any_change || step_rise;
  assign tmr_run     = (st_q == ST_RUN);
  assign blink_on    = ~(tick_cnt[BLINK_W-1] | tick_cnt[BLINK_W-2]);

  idle_timer #(
    .PRESC_DIV (PRESC_DIV),
    .TMR_W     (TMR_W),
    .OVF_LIMIT (OVF_LIMIT)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (tmr_restart),
    .run     (tmr_run),
    .expire  (expire)
  );

  blink_gen #(
    .TICK_DIV (TICK_DIV),
    .CNT_W    (BLINK_W)
  ) u_blink (
    .clk      (clk),
    .rst      (rst),
    .tick_cnt (tick_cnt)
  );

  level_reducer #(
    .FIELD_W (FIELD_W),
    .FIELD_N (FIELD_N),
    .PHASE_W (PHASE_W)
  ) u_red_a (
    .word_in  (wa_q),
    .word_out (red_a)
  );

  level_reducer #(
    .FIELD_W (FIELD_W),
    .FIELD_N (FIELD_N),
    .PHASE_W (PHASE_W)
  ) u_red_b (
    .word_in  (wb_q),
    .word_out (red_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_OFF;
      wa_q  <= '0;
      wb_q  <= '0;
      led_q <= 1'b1;
    end else if (en_n) begin
      st_q  <= ST_OFF;
      wa_q  <= '0;
      wb_q  <= '0;
      led_q <= blink_on;
    end else if (st_q == ST_OFF) begin
      st_q  <= ST_RUN;
      wa_q  <= word_a_in;
      wb_q  <= word_b_in;
      led_q <= 1'b0;
    end else if (step_rise) begin
      st_q  <= ST_RUN;
      wa_q  <= word_a_in;
      wb_q  <= word_b_in;
      led_q <= 1'b0;
    end else if (any_change) begin
      st_q  <= ST_RUN;
      led_q <= 1'b0;
    end else if (expire) begin
      st_q  <= ST_LOW;
      wa_q  <= red_a;
      wb_q  <= red_b;
      led_q <= 1'b1;
    end
  end

  assign word_a_out = wa_q;
  assign word_b_out = wb_q;
  assign lowpwr_led = led_q;

  // R2: disabled drive gives zero words
  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (word_a_out == '0 && word_b_out == '0));

  // R4: a step loads fresh words at full power
  p_step_loads_r4: assert property (@(posedge clk) disable iff (rst)
    (!en_n && step_rise) |=>
      (word_a_out == $past(word_a_in) && word_b_out == $past(word_b_in) && !lowpwr_led));

  // R5: a change without step keeps the words, indicator off
  p_change_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (!en_n && any_change && !step_rise && st_q != ST_OFF) |=>
      ($stable(word_a_out) && $stable(word_b_out) && !lowpwr_led));

  // R7: a timeout lowers the words once, phase kept, indicator on
  p_reduce_once_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && expire && !en_n && !any_change && !step_rise) |=>
      (st_q == ST_LOW && lowpwr_led &&
       word_a_out <= $past(word_a_out) && word_b_out <= $past(word_b_out) &&
       word_a_out[PHASE_W-1:0] == $past(word_a_out[PHASE_W-1:0]) &&
       word_b_out[PHASE_W-1:0] == $past(word_b_out[PHASE_W-1:0])));

  // R8: reduced state is held with no activity
  p_low_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOW && !en_n && !any_change && !step_rise) |=>
      (st_q == ST_LOW && $stable(word_a_out) && $stable(word_b_out) && lowpwr_led));

endmodule

// File: tb/tb_stp_idle_reducer.sv
module tb_stp_idle_reducer;

  localparam int PD = 2;
  localparam int TW = 3;
  localparam int OL = 2;
  localparam int BD = 2;
  localparam int N  = PD * (1 << TW) * OL;

  logic       clk = 1'b0;
  logic       rst;
  logic       en_n;
  logic       any_change;
  logic       step_rise;
  logic [7:0] word_a_in, word_b_in;
  logic [7:0] word_a_out, word_b_out;
  logic       lowpwr_led;

  always #5 clk = ~clk;

  stp_idle_reducer #(
    .PRESC_DIV (PD),
    .TMR_W     (TW),
    .OVF_LIMIT (OL),
    .TICK_DIV  (BD),
    .BLINK_W   (7),
    .FIELD_W   (2),
    .FIELD_N   (2),
    .PHASE_W   (4)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .en_n       (en_n),
    .any_change (any_change),
    .step_rise  (step_rise),
    .word_a_in  (word_a_in),
    .word_b_in  (word_b_in),
    .word_a_out (word_a_out),
    .word_b_out (word_b_out),
    .lowpwr_led (lowpwr_led)
  );

  typedef struct {
    int         cyc;
    logic [7:0] a;
    logic [7:0] b;
    logic       led;
    string      req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic logic [1:0] lvl_down(input logic [1:0] v);
    case (v)
      2'd3:    return 2'd2;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] lower(input logic [7:0] w);
    return {lvl_down(w[7:6]), lvl_down(w[5:4]), w[3:0]};
  endfunction

  function automatic logic led_at(input int k);
    int t;
    t = ((k - 1) / BD) % 128;
    return ((t >> 5) & 3) == 0;
  endfunction

  task automatic compare(input logic [7:0] a, input logic [7:0] b, input logic led,
                         input string req, input int at);
    n_cmp++;
    if (word_a_out !== a || word_b_out !== b || lowpwr_led !== led) begin
      n_bad++;
      $display("FAIL %s cyc %0d: got a=%h b=%h led=%b, exp a=%h b=%h led=%b",
               req, at, word_a_out, word_b_out, lowpwr_led, a, b, led);
    end
  endtask

  // monitor: pops due items and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.cyc < cyc) begin
        n_cmp++;
        n_bad++;
        $display("FAIL %s cyc %0d: check missed, expected at cyc %0d", it.req, cyc, it.cyc);
      end else begin
        compare(it.a, it.b, it.led, it.req, cyc);
      end
    end
  end

  task automatic push(input int at, input logic [7:0] a, input logic [7:0] b,
                      input logic led, input string req);
    item_t it;
    it.cyc = at; it.a = a; it.b = b; it.led = led; it.req = req;
    q.push_back(it);
  endtask

  task automatic apply(input logic en, input logic chg, input logic stp,
                       input logic [7:0] a, input logic [7:0] b, output int c);
    @(negedge clk);
    c = cyc;
    en_n = en; any_change = chg; step_rise = stp;
    word_a_in = a; word_b_in = b;
  endtask

  task automatic release_strobes();
    @(negedge clk);
    any_change = 1'b0;
    step_rise  = 1'b0;
  endtask

  task automatic wait_until(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout, exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c, c2;
    logic [7:0] ha, hb;
    rst = 1'b1; en_n = 1'b1; any_change = 1'b0; step_rise = 1'b0;
    word_a_in = 8'h00; word_b_in = 8'h00;
    repeat (3) @(negedge clk);
    compare(8'h00, 8'h00, 1'b1, "R1 in reset", 0);
    rst = 1'b0;
    @(negedge clk);
    compare(8'h00, 8'h00, 1'b1, "R1 after reset", cyc);

    // R10 and R2: blink phases while disabled, words zero
    push(10,  8'h00, 8'h00, led_at(10),  "R10 blink on");
    push(70,  8'h00, 8'h00, led_at(70),  "R10 blink off bit5");
    push(200, 8'h00, 8'h00, led_at(200), "R10 blink off bit6");
    push(260, 8'h00, 8'h00, led_at(260), "R10 blink wrap on");
    wait_until(262);

    // R3: enable loads words; then R6 timing, R7 levels, R8 hold
    apply(1'b0, 1'b1, 1'b0, 8'hC5, 8'hD5, c);
    push(c + 1, 8'hC5, 8'hD5, 1'b0, "R3 enable load");
    push(c + 2, 8'hC5, 8'hD5, 1'b0, "R5 inputs ignored without step");
    push(c + N, 8'hC5, 8'hD5, 1'b0, "R6 not yet timed out");
    push(c + N + 1, lower(8'hC5), lower(8'hD5), 1'b1, "R7 R9 first reduction");
    push(c + N + 21, lower(8'hC5), lower(8'hD5), 1'b1, "R8 held reduced");
    push(c + N + 41, lower(8'hC5), lower(8'hD5), 1'b1, "R8 still once only");
    release_strobes();
    word_a_in = 8'hFF; word_b_in = 8'hFF;
    wait_until(c + N + 42);

    // R5 and R11: change without step re-arms, second reduction
    ha = lower(8'hC5); hb = lower(8'hD5);
    apply(1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, c);
    push(c + 1, ha, hb, 1'b0, "R5 change keeps words");
    push(c + N, ha, hb, 1'b0, "R11 re-armed not yet");
    push(c + N + 1, lower(ha), lower(hb), 1'b1, "R11 second reduction");
    release_strobes();
    wait_until(c + N + 2);

    // R4: step from reduced restores; R6 restart by a mid-count change
    apply(1'b0, 1'b1, 1'b1, 8'hF9, 8'hB9, c);
    push(c + 1, 8'hF9, 8'hB9, 1'b0, "R4 step restores full");
    release_strobes();
    wait_until(c + 20);
    apply(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, c2);
    push(c + N + 1, 8'hF9, 8'hB9, 1'b0, "R6 restart delays timeout");
    push(c2 + N, 8'hF9, 8'hB9, 1'b0, "R6 restarted not yet");
    push(c2 + N + 1, lower(8'hF9), lower(8'hB9), 1'b1, "R7 fields 3 and 2");
    release_strobes();
    wait_until(c2 + N + 2);

    // R4 and R7: zero field stays zero
    apply(1'b0, 1'b1, 1'b1, 8'h36, 8'hF6, c);
    push(c + 1, 8'h36, 8'hF6, 1'b0, "R4 step from reduced");
    push(c + N + 1, lower(8'h36), lower(8'hF6), 1'b1, "R7 zero field saturates");
    release_strobes();
    wait_until(c + N + 2);

    // R12: disable from reduced; R2 step ignored while disabled; R10 blink
    apply(1'b1, 1'b1, 1'b0, 8'hAA, 8'hAA, c);
    push(c + 1, 8'h00, 8'h00, led_at(c + 1), "R12 disable clears");
    release_strobes();
    apply(1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, c2);
    push(c2 + 1, 8'h00, 8'h00, led_at(c2 + 1), "R2 step while disabled");
    push(c2 + 90, 8'h00, 8'h00, led_at(c2 + 90), "R10 blink after disable");
    release_strobes();
    wait_until(c2 + 91);

    // R3 re-enable, then R12 disable from active
    apply(1'b0, 1'b1, 1'b0, 8'hC9, 8'h79, c);
    push(c + 1, 8'hC9, 8'h79, 1'b0, "R3 re-enable load");
    release_strobes();
    wait_until(c + 10);
    apply(1'b1, 1'b1, 1'b0, 8'hC9, 8'h79, c);
    push(c + 1, 8'h00, 8'h00, led_at(c + 1), "R12 disable from active");
    release_strobes();
    wait_until(c + 3);

    while (q.size() > 0) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule